// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3-style SDRAM and carries the memory from power-on, or from a reset taken while power stays up, to a state where normal traffic may begin. It drives the device reset pin, the clock enable and the command bus. These are chip select, row strobe, column strobe, write enable, bank address and address. No other logic may touch these pins until the sequencer reports that it is ready.

Two requests start the sequence. A cold request, which is also taken on release of the block's own reset, holds the device in reset for the long power-up time. A warm request holds it for the short stable-power time. After the hold, the device reset is released while the clock enable stays low for a stabilization time. The clock enable then rises, and the bus idles with no-operation commands for a settling period. All four mode registers are then written in a fixed order, spaced by the register-set gap. A long ZQ calibration follows. Ready is raised once both the calibration time and the DLL lock time have run out. Every delay is a parameter counted in controller clock cycles. A new request at any moment throws away the progress made so far.

Top module: `sdram_init_seq`

## Requirements
- R1: After `rst_n` is released, or after a cycle with `cold_req` high, `ddr_reset_n` is low for exactly `T_RST_COLD` cycles and then high.
- R2: After a cycle with `warm_req` high and `cold_req` low, `ddr_reset_n` is low for exactly `T_RST_WARM` cycles and then high.
- R3: `ddr_cke` is low whenever `ddr_reset_n` is low. It stays low for `T_STAB` cycles after `ddr_reset_n` rises and then goes high.
- R4: Exactly four mode register writes (`ddr_cs_n`, `ddr_ras_n`, `ddr_cas_n`, `ddr_we_n` all low) are issued, with `ddr_ba` equal to 2, 3, 1 and 0 in that order. Each carries the address parameter for that register. The write with `ddr_ba`=0 also has address bit 8 (DLL reset) set. The first write comes `T_XPR` cycles after `ddr_cke` rises.
- R5: Consecutive mode register writes are exactly `T_MRD` cycles apart.
- R6: While `ddr_cke` is low the bus carries deselect (all four command strobes high). While `ddr_cke` is high, every cycle that is not a mode register write or ZQ calibration carries NOP (`ddr_cs_n` low, other strobes high), including every cycle in the ready state. `ddr_ba` and `ddr_addr` are zero on those cycles.
- R7: A ZQ long calibration (`ddr_cs_n` low, `ddr_ras_n` high, `ddr_cas_n` high, `ddr_we_n` low, address bit 10 set, all other address and bank bits zero) is issued exactly `T_MOD` cycles after the last mode register write.
- R8: `ready` rises at the later of `T_ZQINIT` cycles after the ZQ calibration command and `T_DLLK` cycles after the DLL-reset register write. It then stays high until the next request or reset.
- R9: `init_done` is high for exactly one cycle, the first cycle in which `ready` is high.
- R10: A request in any state, ready included, makes `ddr_reset_n`, `ddr_cke` and `ready` low in the next cycle and restarts the hold count from the beginning.
- R11: When `cold_req` and `warm_req` are high in the same cycle, the cold hold time is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low block reset; release starts a cold sequence |
| cold_req | input | 1 | Start (or restart) with the power-up hold time |
| warm_req | input | 1 | Start (or restart) with the stable-power hold time |
| ddr_reset_n | output | 1 | Device reset, active low |
| ddr_cke | output | 1 | Device clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address (selects the mode register) |
| ddr_addr | output | ADDR_W | Address bus (mode register contents, ZQ long flag) |
| ready | output | 1 | Level: initialization complete |
| init_done | output | 1 | One-cycle pulse on completion |

## Verification
A wrong count or state shows on the pins at once. The reset and clock-enable pins, and each strobe cycle, are compared every cycle against a timeline computed from the parameters. A hold or gap that is off by one therefore fails in the very cycle it ends early or late. A wrong register index shows as a wrong bank or address value during that write. A lost DLL count shows as `ready` rising one or more cycles early. A missed abort shows one cycle after the request, as the reset pin still high.

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq #(
  parameter int ADDR_W     = 14,
  parameter int BA_W       = 3,
  parameter int T_RST_COLD = 40000,
  parameter int T_RST_WARM = 20,
  parameter int T_STAB     = 100,
  parameter int T_XPR      = 10,
  parameter int T_MRD      = 4,
  parameter int T_MOD      = 12,
  parameter int T_ZQINIT   = 512,
  parameter int T_DLLK     = 512,
  parameter logic [ADDR_W-1:0] MR0_VAL = '0,
  parameter logic [ADDR_W-1:0] MR1_VAL = '0,
  parameter logic [ADDR_W-1:0] MR2_VAL = '0,
  parameter logic [ADDR_W-1:0] MR3_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_req,
  input  logic              warm_req,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              ready,
  output logic              init_done
);

  localparam int TSUM  = T_RST_COLD + T_RST_WARM + T_STAB + T_XPR + T_MRD + T_MOD + T_ZQINIT;
  localparam int CNT_W = $clog2(TSUM + 1);
  localparam int DLL_W = $clog2(T_DLLK + 1);

  localparam logic [CNT_W-1:0] L_COLD = CNT_W'(T_RST_COLD - 1);
  localparam logic [CNT_W-1:0] L_WARM = CNT_W'(T_RST_WARM - 1);
  localparam logic [CNT_W-1:0] L_STAB = CNT_W'(T_STAB - 1);
  localparam logic [CNT_W-1:0] L_XPR  = CNT_W'(T_XPR - 1);
  localparam logic [CNT_W-1:0] L_MRD  = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] L_MOD  = CNT_W'(T_MOD - 2);
  localparam logic [CNT_W-1:0] L_ZQ   = CNT_W'(T_ZQINIT - 2);
  localparam logic [DLL_W-1:0] L_DLL  = DLL_W'(T_DLLK - 2);

  localparam logic [ADDR_W-1:0] DLL_RST_BIT = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] ZQ_LONG_BIT = ADDR_W'(1) << 10;

  typedef enum logic [2:0] {
    S_HOLD, S_STAB, S_XPR, S_MRS, S_GAP, S_ZQCL, S_ZQW, S_RDY
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [DLL_W-1:0]  dll;
  logic [1:0]        idx;
  logic              done_r;
  logic [BA_W-1:0]   mr_ba;
  logic [ADDR_W-1:0] mr_val;

  wire last_mr = (idx == 2'd3);
  wire cnt_end = (cnt == '0);

  always_comb begin
    case (idx)
      2'd0:    begin mr_ba = BA_W'(2); mr_val = MR2_VAL; end
      2'd1:    begin mr_ba = BA_W'(3); mr_val = MR3_VAL; end
      2'd2:    begin mr_ba = BA_W'(1); mr_val = MR1_VAL; end
      default: begin mr_ba = BA_W'(0); mr_val = MR0_VAL | DLL_RST_BIT; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_HOLD;
      cnt    <= L_COLD;
      dll    <= '0;
      idx    <= 2'd0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (dll != '0) dll <= dll - 1'b1;
      if (cold_req || warm_req) begin
        state <= S_HOLD;
        cnt   <= cold_req ? L_COLD : L_WARM;
        dll   <= '0;
        idx   <= 2'd0;
      end else begin
        case (state)
          S_HOLD: if (cnt_end) begin state <= S_STAB; cnt <= L_STAB; end
                  else cnt <= cnt - 1'b1;
          S_STAB: if (cnt_end) begin state <= S_XPR; cnt <= L_XPR; end
                  else cnt <= cnt - 1'b1;
          S_XPR:  if (cnt_end) state <= S_MRS;
                  else cnt <= cnt - 1'b1;
          S_MRS: begin
            state <= S_GAP;
            if (last_mr) begin
              cnt <= L_MOD;
              dll <= L_DLL;
            end else begin
              cnt <= L_MRD;
            end
          end
          S_GAP: if (cnt_end) begin
                   if (last_mr) state <= S_ZQCL;
                   else begin state <= S_MRS; idx <= idx + 2'd1; end
                 end else cnt <= cnt - 1'b1;
          S_ZQCL: begin state <= S_ZQW; cnt <= L_ZQ; end
          S_ZQW: begin
            if (!cnt_end) cnt <= cnt - 1'b1;
            if (cnt_end && dll == '0) begin
              state  <= S_RDY;
              done_r <= 1'b1;
            end
          end
          default: state <= S_RDY;
        endcase
      end
    end
  end

  wire is_mrs = (state == S_MRS);
  wire is_zq  = (state == S_ZQCL);

  assign ddr_reset_n = (state != S_HOLD);
  assign ddr_cke     = (state != S_HOLD) && (state != S_STAB);
  assign ddr_cs_n    = !ddr_cke;
  assign ddr_ras_n   = !is_mrs;
  assign ddr_cas_n   = !is_mrs;
  assign ddr_we_n    = !(is_mrs || is_zq);
  assign ddr_ba      = is_mrs ? mr_ba : '0;
  assign ddr_addr    = is_mrs ? mr_val : (is_zq ? ZQ_LONG_BIT : '0);
  assign ready       = (state == S_RDY);
  assign init_done   = done_r;

endmodule

module sdram_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cold_req,
  input logic warm_req,
  input logic ddr_reset_n,
  input logic ddr_cke,
  input logic ddr_cs_n,
  input logic ddr_ras_n,
  input logic ddr_cas_n,
  input logic ddr_we_n,
  input logic ready,
  input logic init_done
);
  wire mrs = !ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n;
  wire nop = !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n;

  assert_cke_needs_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |-> ddr_reset_n);
  assert_cke_low_at_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ddr_reset_n) |-> !ddr_cke);
  assert_deselect_cke_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cke |-> (ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n));
  assert_mrs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mrs |=> !mrs);
  assert_ready_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> nop);
  assert_done_in_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ready);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_req || warm_req) |=> (!ddr_reset_n && !ddr_cke && !ready));
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
  .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
  .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
  .ready(ready), .init_done(init_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  localparam int AW = 14, BW = 3;
  localparam int TC = 300, TWM = 20, TS = 40, TX = 8, TM = 4, TMOD = 12, TZQ = 64, TD = 100;
  localparam logic [AW-1:0] V0 = 14'h0A30, V1 = 14'h0044, V2 = 14'h0018, V3 = 14'h0004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cold_req = 1'b0, warm_req = 1'b0;
  logic ddr_reset_n, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ready, init_done;
  logic [BW-1:0] ddr_ba;
  logic [AW-1:0] ddr_addr;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(AW), .BA_W(BW), .T_RST_COLD(TC), .T_RST_WARM(TWM), .T_STAB(TS),
    .T_XPR(TX), .T_MRD(TM), .T_MOD(TMOD), .T_ZQINIT(TZQ), .T_DLLK(TD),
    .MR0_VAL(V0), .MR1_VAL(V1), .MR2_VAL(V2), .MR3_VAL(V3)
  ) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
    .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
    .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .ready(ready), .init_done(init_done)
  );

  int cyc = 0, checks = 0, fails = 0, k = 0;
  bit cold_path = 1'b1, fresh_req = 1'b0, both_req = 1'b0, mon_on = 1'b0;
  logic rst_q = 1'b0, cold_q = 1'b0, warm_q = 1'b0;

  // {reset_n, cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready, done}
  function automatic logic [24:0] expect_at(input int t, input bit cold);
    int trst, s, m0, zq, d;
    logic [BW-1:0] ba;
    logic [AW-1:0] ad;
    logic [3:0] cmd;
    logic rn, ck, rd, dn;
    trst = cold ? TC : TWM;
    s  = trst + TS + TX;
    m0 = s + 3 * TM;
    zq = m0 + TMOD;
    d  = (zq + TZQ > m0 + TD) ? zq + TZQ : m0 + TD;
    rn = (t >= trst);
    ck = (t >= trst + TS);
    cmd = ck ? 4'b0111 : 4'b1111;
    ba = '0; ad = '0; rd = 1'b0; dn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (t == s + i * TM) begin
        cmd = 4'b0000;
        case (i)
          0: begin ba = 3'd2; ad = V2; end
          1: begin ba = 3'd3; ad = V3; end
          2: begin ba = 3'd1; ad = V1; end
          default: begin ba = 3'd0; ad = V0 | 14'h0100; end
        endcase
      end
    end
    if (t == zq) begin cmd = 4'b0110; ad = 14'h0400; end
    if (t >= d) rd = 1'b1;
    if (t == d) dn = 1'b1;
    return {rn, ck, cmd, ba, ad, rd, dn};
  endfunction

  function automatic string tag_at(input int t, input bit cold, input bit fr, input bit both);
    int trst, s, m0, zq, d;
    trst = cold ? TC : TWM;
    s  = trst + TS + TX;
    m0 = s + 3 * TM;
    zq = m0 + TMOD;
    d  = (zq + TZQ > m0 + TD) ? zq + TZQ : m0 + TD;
    if (t == 0 && both) return "R11";
    if (t == 0 && fr) return "R10";
    if (t < trst) return cold ? "R1" : "R2";
    if (t < s) return "R3";
    if (t <= m0 && ((t - s) % TM) == 0) return "R4";
    if (t < m0) return "R5";
    if (t < zq) return "R6";
    if (t == zq) return "R7";
    if (t == d) return "R9";
    return "R8";
  endfunction

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    rst_q  <= rst_n;
    cold_q <= cold_req;
    warm_q <= warm_req;
  end

  always @(negedge clk) begin
    logic [24:0] got, exp;
    fresh_req = 1'b0;
    if (!rst_q) begin k = cyc; cold_path = 1'b1; both_req = 1'b0; end
    else if (cold_q || warm_q) begin
      k = cyc; cold_path = cold_q; fresh_req = 1'b1; both_req = cold_q && warm_q;
    end
    if (mon_on) begin
      got = {ddr_reset_n, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n,
             ddr_ba, ddr_addr, ready, init_done};
      exp = expect_at(cyc - k, cold_path);
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s t=%0d actual=%h expected=%h",
                 tag_at(cyc - k, cold_path, fresh_req, both_req), cyc - k, got, exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL R8 watchdog actual=%0d cycles expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic pulse(input bit c, input bit w);
    @(negedge clk);
    cold_req = c; warm_req = w;
    @(negedge clk);
    cold_req = 1'b0; warm_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    mon_on = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;                 // cold path via reset release: R1, R3..R9
    repeat (650) @(negedge clk);
    pulse(1'b0, 1'b1);            // warm path: R2
    repeat (400) @(negedge clk);
    pulse(1'b1, 1'b1);            // both at once: R11
    repeat (650) @(negedge clk);
    pulse(1'b0, 1'b1);            // abort during MR writes: R10
    repeat (TWM + TS + TX + 5) @(negedge clk);
    pulse(1'b1, 1'b0);
    repeat (120) @(negedge clk);
    rst_n = 1'b0;                 // reset mid-hold
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (650) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      int kind, gap;
      kind = int'($urandom % 3);
      gap  = int'($urandom % 700);
      pulse(kind != 1, kind != 0);
      repeat (gap) @(negedge clk);
    end
    pulse(1'b0, 1'b1);
    repeat (400) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule